// File: doc/BRIEF.md
# Bus Fault, Halt and Reset Controller

This block watches every bus cycle a processor core starts and supervises the system control lines around it. An acknowledge-timeout timer turns a missing acknowledge into a bus error. A fault monitor then picks one of three outcomes:
- a bus error seen together with a low halt line floats the bus and reruns the cycle once both lines are released;
- a bus error with the halt line high asks the core to take an error exception;
- a second bus error before the system has recovered from the first latches a halted state that only reset can clear.

The same block handles the bidirectional reset line. It qualifies an incoming reset request. The very first request after power-up needs a longer hold than later ones. On a software command it drives a fixed-length reset pulse onto the line. On a recognized reset it loads the core's supervisor flag, trace flag and interrupt mask with their reset values. The core may otherwise update those flags through a write port.

Top module: `busfault_ctrl`

## Requirements
- R1: With `cyc_active_i` high and `ack_i` low, `berr_o` rises in the cycle after the TL-th consecutive sampling edge, where TL is `tmo_limit_i` (TL >= 1). An edge sampling `ack_i` high or `cyc_active_i` low clears and disarms the count.
- R2: A new bus error sampled while the halt line is low sets `float_o` after that edge. Once bus error and halt are both sampled inactive, `retry_o` pulses high for exactly one cycle and `float_o` drops. The sequence can repeat any number of times.
- R3: A new bus error sampled in normal operation while the halt line is high pulses `exc_o` for one cycle and leaves `float_o` low and `halt_no` high.
- R4: After an exception, a bus cycle sampled with `ack_i` high and no bus error counts as recovery. A new bus error before that recovery enters a halted state: `halt_no` is driven low and `float_o` is high. Further bus error and halt activity neither clears this state nor produces `retry_o`.
- R5: Once the power-on request has been served, a reset is recognized only when the reset line and the halt line are both sampled low on RST_QUAL_CLKS (default 10) consecutive edges. `reset_rec_o` then pulses for one cycle. A shorter hold, or a low reset line with the halt line high, is not recognized.
- R6: The first reset request after `rst_ni` needs only the reset line to be sampled low on POR_HOLD_CLKS consecutive edges, whatever the halt line does.
- R7: A one-cycle `sw_reset_i` drives `reset_drive_no` low for exactly RST_PULSE_CLKS (default 124) clock periods. A command during the pulse neither restarts nor extends it. The pulse changes no flag and no fault state.
- R8: While the block itself drives the reset line low, that low level is never recognized as a reset request, even with the halt line low.
- R9: A recognized reset sets `sup_o` to 1, clears `trace_o`, sets `imask_o` to 3'b111 and, on the next edge, leaves the halted state. At other times `flag_we_i` loads the three flags from `flag_sup_i`, `flag_trace_i` and `flag_mask_i`.
- R10: The halt line low without a bus error sets `float_o` after the sampling edge and clears it after the edge that samples it high again, with no `retry_o` and no `exc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| tmo_limit_i | input | TMO_W | Acknowledge timeout in clocks |
| cyc_active_i | input | 1 | A bus cycle is in progress |
| ack_i | input | 1 | Cycle acknowledge from the addressed device |
| berr_ni | input | 1 | External bus error line, active low |
| halt_ni | input | 1 | Halt line as seen on the board, active low |
| reset_ni | input | 1 | Reset line as seen on the board, active low |
| sw_reset_i | input | 1 | Software command to pulse the reset line |
| flag_we_i | input | 1 | Load the core flags |
| flag_sup_i | input | 1 | Supervisor flag write value |
| flag_trace_i | input | 1 | Trace flag write value |
| flag_mask_i | input | 3 | Interrupt mask write value |
| berr_o | output | 1 | Bus error active (timeout or external) |
| halt_no | output | 1 | Halt line drive, low in the halted state |
| float_o | output | 1 | Request to float the bus |
| retry_o | output | 1 | One-cycle request to rerun the faulted cycle |
| exc_o | output | 1 | One-cycle request for a bus error exception |
| reset_rec_o | output | 1 | One-cycle pulse on a recognized reset |
| reset_drive_no | output | 1 | Open-drain reset drive, low while pulsing |
| sup_o | output | 1 | Supervisor flag |
| trace_o | output | 1 | Trace flag |
| imask_o | output | 3 | Interrupt mask |

## Verification
The hardest state to reach is a genuine double fault. The stimulus must raise an exception, keep every cycle un-acknowledged, and then produce a fresh bus error edge rather than a continuing level. The bench releases and reasserts the external bus error line with no acked cycle in between. It contrasts this with the same pattern separated by an acked cycle, which must give a second exception instead. The self-generated reset pulse is checked against recognition by holding the board halt line low for the whole pulse. The reset and halt lines are modelled as wired-AND nets, so the controller sees its own drive exactly as a real board would show it.

// File: rtl/bft_pkg.sv
package bft_pkg;
  typedef enum logic [1:0] {
    FS_RUN    = 2'd0,
    FS_FLOAT  = 2'd1,
    FS_PEND   = 2'd2,
    FS_HALTED = 2'd3
  } fault_st_e;

  typedef struct packed {
    logic       sup;
    logic       trace;
    logic [2:0] mask;
  } cpu_flags_t;

  localparam cpu_flags_t FLAGS_ON_RESET = '{sup: 1'b1, trace: 1'b0, mask: 3'b111};
endpackage

// File: rtl/bft_ack_timer.sv
module bft_ack_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] lim_i,
  input  logic          cyc_i,
  input  logic          ack_i,
  output logic          tmo_o
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_o <= 1'b0;
    end else if (clr_i || !cyc_i || ack_i) begin
      cnt_q <= '0;
      tmo_o <= 1'b0;
    end else if (!tmo_o) begin
      cnt_q <= cnt_inc[TW-1:0];
      if (cnt_inc >= {1'b0, lim_i}) tmo_o <= 1'b1;
    end
  end

  // R1
  a_r1_tmo_needs_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> $past(cyc_i && !ack_i && !clr_i));
  a_r1_tmo_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_i || ack_i) |=> !tmo_o);
endmodule

// File: rtl/bft_fault_fsm.sv
module bft_fault_fsm
  import bft_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic berr_i,
  input  logic halt_i,
  input  logic cyc_i,
  input  logic ack_i,
  output logic float_o,
  output logic halt_drv_o,
  output logic retry_o,
  output logic exc_o
);
  fault_st_e st_q, st_d;
  logic berr_q, halt_q;
  logic retry_d, exc_d;
  logic berr_ev;

  assign berr_ev = berr_i & ~berr_q;

  always_comb begin
    st_d    = st_q;
    retry_d = 1'b0;
    exc_d   = 1'b0;
    unique case (st_q)
      FS_RUN: begin
        if (berr_ev) begin
          if (halt_i) begin
            st_d = FS_FLOAT;
          end else begin
            st_d  = FS_PEND;
            exc_d = 1'b1;
          end
        end
      end
      FS_FLOAT: begin
        if (!berr_i && !halt_i) begin
          st_d    = FS_RUN;
          retry_d = 1'b1;
        end
      end
      FS_PEND: begin
        if (berr_ev) st_d = FS_HALTED;
        else if (cyc_i && ack_i && !berr_i) st_d = FS_RUN;
      end
      FS_HALTED: st_d = FS_HALTED;
      default: st_d = FS_RUN;
    endcase
    if (clr_i) begin
      st_d    = FS_RUN;
      retry_d = 1'b0;
      exc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FS_RUN;
      berr_q  <= 1'b0;
      halt_q  <= 1'b0;
      retry_o <= 1'b0;
      exc_o   <= 1'b0;
    end else begin
      st_q    <= st_d;
      berr_q  <= berr_i;
      halt_q  <= halt_i;
      retry_o <= retry_d;
      exc_o   <= exc_d;
    end
  end

  assign halt_drv_o = (st_q == FS_HALTED);
  assign float_o    = (st_q == FS_FLOAT) || (st_q == FS_HALTED) || halt_q;

  // R2
  a_r2_retry_from_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> $past(st_q == FS_FLOAT));
  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({retry_o, exc_o}));
  // R3
  a_r3_exc_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $past(st_q == FS_RUN && !halt_i));
  // R4
  a_r4_halted_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FS_HALTED && !clr_i) |=> (st_q == FS_HALTED));
  a_r4_halted_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_drv_o |-> (float_o && !retry_o));
endmodule

// File: rtl/bft_reset_ctl.sv
module bft_reset_ctl
  import bft_pkg::*;
#(
  parameter int RQ    = 10,
  parameter int POR   = 16,
  parameter int PULSE = 124
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_line_i,
  input  logic       halt_i,
  input  logic       sw_rst_i,
  input  logic       flag_we_i,
  input  cpu_flags_t flag_i,
  output logic       rec_o,
  output logic       drive_o,
  output cpu_flags_t flags_o
);
  localparam int QMAX = (POR > RQ) ? POR : RQ;
  localparam int QW   = $clog2(QMAX + 1);
  localparam int PCW  = $clog2(PULSE + 1);

  logic           por_pend_q;
  logic [QW-1:0]  qcnt_q, need, need_m1;
  logic [PCW-1:0] pcnt_q;
  logic           cond, hit;

  assign need    = por_pend_q ? QW'(POR) : QW'(RQ);
  assign need_m1 = need - QW'(1);
  // own pulse never counts as a request
  assign cond    = rst_line_i && !drive_o && (por_pend_q || halt_i);
  assign hit     = cond && (qcnt_q == need_m1);
  assign drive_o = (pcnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_pend_q <= 1'b1;
      qcnt_q     <= '0;
      rec_o      <= 1'b0;
    end else begin
      rec_o <= hit;
      if (!cond) qcnt_q <= '0;
      else if (hit) qcnt_q <= QW'(QMAX);
      else if (qcnt_q < need) qcnt_q <= qcnt_q + QW'(1);
      if (hit) por_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else if (pcnt_q != '0) pcnt_q <= pcnt_q - PCW'(1);
    else if (sw_rst_i) pcnt_q <= PCW'(PULSE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= FLAGS_ON_RESET;
    else if (hit) flags_o <= FLAGS_ON_RESET;
    else if (flag_we_i) flags_o <= flag_i;
  end

  // R5
  a_r5_rec_needs_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_o |-> $past(rst_line_i));
  a_r5_rec_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_o |=> !rec_o);
  // R7
  a_r7_pulse_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> $past(sw_rst_i));
  // R8
  a_r8_no_self_rec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(drive_o) |-> !rec_o);
  // R9
  a_r9_flags_on_rec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_o |-> (flags_o == FLAGS_ON_RESET));
endmodule

// File: rtl/busfault_ctrl.sv
module busfault_ctrl
  import bft_pkg::*;
#(
  parameter int TMO_W          = 8,
  parameter int RST_QUAL_CLKS  = 10,
  parameter int POR_HOLD_CLKS  = 16,
  parameter int RST_PULSE_CLKS = 124
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             cyc_active_i,
  input  logic             ack_i,
  input  logic             berr_ni,
  input  logic             halt_ni,
  input  logic             reset_ni,
  input  logic             sw_reset_i,
  input  logic             flag_we_i,
  input  logic             flag_sup_i,
  input  logic             flag_trace_i,
  input  logic [2:0]       flag_mask_i,
  output logic             berr_o,
  output logic             halt_no,
  output logic             float_o,
  output logic             retry_o,
  output logic             exc_o,
  output logic             reset_rec_o,
  output logic             reset_drive_no,
  output logic             sup_o,
  output logic             trace_o,
  output logic [2:0]       imask_o
);
  logic       tmo, halt_drv, drive;
  cpu_flags_t flag_wr, flags;

  assign flag_wr = '{sup: flag_sup_i, trace: flag_trace_i, mask: flag_mask_i};

  bft_ack_timer #(.TW(TMO_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reset_rec_o),
    .lim_i  (tmo_limit_i),
    .cyc_i  (cyc_active_i),
    .ack_i  (ack_i),
    .tmo_o  (tmo)
  );

  assign berr_o = tmo | ~berr_ni;

  bft_fault_fsm u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (reset_rec_o),
    .berr_i     (berr_o),
    .halt_i     (~halt_ni),
    .cyc_i      (cyc_active_i),
    .ack_i      (ack_i),
    .float_o    (float_o),
    .halt_drv_o (halt_drv),
    .retry_o    (retry_o),
    .exc_o      (exc_o)
  );

  bft_reset_ctl #(
    .RQ    (RST_QUAL_CLKS),
    .POR   (POR_HOLD_CLKS),
    .PULSE (RST_PULSE_CLKS)
  ) u_reset (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_line_i (~reset_ni),
    .halt_i     (~halt_ni),
    .sw_rst_i   (sw_reset_i),
    .flag_we_i  (flag_we_i),
    .flag_i     (flag_wr),
    .rec_o      (reset_rec_o),
    .drive_o    (drive),
    .flags_o    (flags)
  );

  assign halt_no        = ~halt_drv;
  assign reset_drive_no = ~drive;
  assign sup_o          = flags.sup;
  assign trace_o        = flags.trace;
  assign imask_o        = flags.mask;
endmodule

// File: tb/busfault_ctrl_test.sv
`timescale 1ns/1ps
module busfault_ctrl_test;
  typedef struct packed {
    logic [7:0] lim;
    logic [7:0] ack_at;
    logic       exp_tmo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd4, 8'd0, 1'b1}, '{8'd4, 8'd3, 1'b0}, '{8'd4, 8'd4, 1'b0}, '{8'd4, 8'd5, 1'b1},
    '{8'd1, 8'd0, 1'b1}, '{8'd7, 8'd2, 1'b0}, '{8'd9, 8'd0, 1'b1}, '{8'd2, 8'd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tmo_limit = 8'd4;
  logic cyc = 1'b0, ack = 1'b0, berr_n = 1'b1;
  logic ext_halt_n = 1'b1, ext_reset_n = 1'b1, sw_reset = 1'b0;
  logic flag_we = 1'b0, f_sup = 1'b0, f_trace = 1'b0;
  logic [2:0] f_mask = 3'd0;
  logic berr_o, halt_no, float_o, retry_o, exc_o, rec_o, drive_no, sup_o, trace_o;
  logic [2:0] imask_o;
  logic halt_line, reset_line;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  assign halt_line  = ext_halt_n & halt_no;
  assign reset_line = ext_reset_n & drive_no;

  always #5 clk = ~clk;

  busfault_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tmo_limit_i(tmo_limit), .cyc_active_i(cyc), .ack_i(ack),
    .berr_ni(berr_n), .halt_ni(halt_line), .reset_ni(reset_line), .sw_reset_i(sw_reset),
    .flag_we_i(flag_we), .flag_sup_i(f_sup), .flag_trace_i(f_trace), .flag_mask_i(f_mask),
    .berr_o(berr_o), .halt_no(halt_no), .float_o(float_o), .retry_o(retry_o), .exc_o(exc_o),
    .reset_rec_o(rec_o), .reset_drive_no(drive_no), .sup_o(sup_o), .trace_o(trace_o),
    .imask_o(imask_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic flags_chk(input string req, input int s, input int t, input int m);
    chk(req, sup_o, s);
    chk(req, trace_o, t);
    chk(req, imask_o, m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int first, excs, low, recs;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // reset state, R9 defaults
    chk("R9 reset berr", berr_o, 0);
    chk("R4 reset halt", halt_no, 1);
    chk("R10 reset float", float_o, 0);
    chk("R7 reset drive", drive_no, 1);
    chk("R5 reset rec", rec_o, 0);
    flags_chk("R9 reset flags", 1, 0, 7);

    // R9 write port
    flag_we = 1; f_sup = 0; f_trace = 1; f_mask = 3'd2;
    tick();
    flag_we = 0;
    flags_chk("R9 flag write", 0, 1, 2);

    // R6 power-on hold: one short of the limit, then full
    ext_reset_n = 0;
    recs = 0;
    for (int e = 1; e <= 15; e++) begin tick(); if (rec_o) recs++; end
    ext_reset_n = 1; tick();
    chk("R6 short por hold", recs, 0);
    ext_reset_n = 0;
    first = 0;
    for (int e = 1; e <= 16; e++) begin tick(); if (rec_o && first == 0) first = e; end
    chk("R6 por recognized edge", first, 16);
    flags_chk("R9 flags after reset", 1, 0, 7);
    tick();
    chk("R5 rec one cycle", rec_o, 0);
    ext_reset_n = 1; tick();

    // R1 vector table
    for (int i = 0; i < NV; i++) begin
      tmo_limit = VECS[i].lim; cyc = 0; ack = 0;
      tick();
      cyc = 1; first = 0; excs = 0;
      for (int e = 1; e <= int'(VECS[i].lim) + 3; e++) begin
        ack = (VECS[i].ack_at != 0) && (e >= int'(VECS[i].ack_at));
        tick();
        if (berr_o && first == 0) first = e;
        if (exc_o) excs++;
      end
      chk($sformatf("R1 vec%0d timeout edge", i), first, VECS[i].exp_tmo ? int'(VECS[i].lim) : 0);
      chk($sformatf("R3 vec%0d exceptions", i), excs, VECS[i].exp_tmo ? 1 : 0);
      cyc = 0; ack = 0; tick();
      cyc = 1; ack = 1; tick();
      cyc = 0; ack = 0; tick();
    end

    // R1 cycle end disarms the count
    tmo_limit = 8'd4; cyc = 1;
    tick(); tick(); tick();
    cyc = 0; tick();
    cyc = 1; first = 0;
    for (int e = 1; e <= 3; e++) begin tick(); if (berr_o) first = e; end
    chk("R1 cycle end clears", first, 0);
    cyc = 0; tick();

    // R5 reset with halt high is ignored
    ext_reset_n = 0; recs = 0;
    for (int e = 1; e <= 30; e++) begin tick(); if (rec_o) recs++; end
    chk("R5 reset without halt", recs, 0);
    ext_halt_n = 0;
    for (int e = 1; e <= 9; e++) begin tick(); if (rec_o) recs++; end
    ext_reset_n = 1; ext_halt_n = 1; tick();
    chk("R5 nine clocks", recs, 0);
    flag_we = 1; f_sup = 0; f_trace = 1; f_mask = 3'd0; tick(); flag_we = 0;
    ext_reset_n = 0; ext_halt_n = 0; first = 0;
    for (int e = 1; e <= 12; e++) begin tick(); if (rec_o && first == 0) first = e; end
    chk("R5 ten clocks", first, 10);
    flags_chk("R9 flags restored", 1, 0, 7);
    ext_reset_n = 1; ext_halt_n = 1; tick(); tick();

    // R2 float and retry, twice
    for (int k = 0; k < 2; k++) begin
      berr_n = 0; ext_halt_n = 0; tick();
      chk("R2 float on berr+halt", float_o, 1);
      chk("R2 no exc", exc_o, 0);
      tick();
      chk("R2 no early retry", retry_o, 0);
      berr_n = 1; ext_halt_n = 1; tick();
      chk("R2 retry pulse", retry_o, 1);
      chk("R2 float released", float_o, 0);
      tick();
      chk("R2 retry one cycle", retry_o, 0);
    end

    // R10 halt alone
    ext_halt_n = 0; tick();
    chk("R10 halt floats", float_o, 1);
    chk("R10 no exc", exc_o, 0);
    ext_halt_n = 1; tick();
    chk("R10 float drops", float_o, 0);
    chk("R10 no retry", retry_o, 0);

    // R3 exception, R4 recovery then double fault
    berr_n = 0; tick();
    chk("R3 exc pulse", exc_o, 1);
    chk("R3 no float", float_o, 0);
    chk("R3 halt high", halt_no, 1);
    berr_n = 1; tick();
    chk("R3 exc one cycle", exc_o, 0);
    cyc = 1; ack = 1; tick();
    cyc = 0; ack = 0;
    berr_n = 0; tick();
    chk("R4 after recovery exc", exc_o, 1);
    chk("R4 not halted", halt_no, 1);
    berr_n = 1; tick();
    berr_n = 0; tick();
    chk("R4 double fault halt", halt_no, 0);
    chk("R4 double fault float", float_o, 1);
    chk("R4 no exc on double", exc_o, 0);
    berr_n = 1; tick();
    berr_n = 0; ext_halt_n = 0; tick();
    berr_n = 1; ext_halt_n = 1; recs = 0;
    for (int e = 1; e <= 4; e++) begin tick(); if (retry_o) recs++; end
    chk("R4 sticky no retry", recs, 0);
    chk("R4 sticky halt", halt_no, 0);
    // R9 reset clears halted (halt line held low by block)
    ext_reset_n = 0; first = 0;
    for (int e = 1; e <= 10; e++) begin tick(); if (rec_o && first == 0) first = e; end
    chk("R9 reset from halted", first, 10);
    tick();
    chk("R9 halted cleared", halt_no, 1);
    ext_reset_n = 1; tick(); tick();

    // R7 / R8 software pulse
    flag_we = 1; f_sup = 0; f_trace = 1; f_mask = 3'd5; tick(); flag_we = 0;
    sw_reset = 1; tick();
    sw_reset = 0;
    low = drive_no ? 0 : 1; recs = 0;
    ext_halt_n = 0;
    for (int e = 1; e <= 200; e++) begin
      sw_reset = (e == 50);
      tick();
      if (!drive_no) low++;
      if (rec_o) recs++;
    end
    sw_reset = 0; ext_halt_n = 1; tick();
    chk("R7 pulse length", low, 124);
    chk("R8 own pulse not recognized", recs, 0);
    flags_chk("R7 flags untouched", 0, 1, 5);
    chk("R7 halt untouched", halt_no, 1);
    chk("R7 float untouched", float_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule